// File: doc/BRIEF.md
# Eight-Input Interrupt Priority Resolver

This block is the decision core of an eight-line interrupt controller. It captures incoming request lines in a request register, either on a rising edge or as a live level, and hides masked lines from arbitration without forgetting them. It then chooses the most urgent unmasked pending request and compares it against the most urgent level already in service. It raises `int_out` only when the new request outranks every level in service. A processor acknowledge strobe accepts the winner. The winner leaves the request register and enters the in-service register, and a vector made from the configured base and the winning level comes out for one cycle.

Priority follows a ring of eight positions. After reset line 0 is first and line 7 is last. An end-of-service command can rotate the ring so that the level just finished drops to the bottom. A separate priority-set pulse places any chosen level at the bottom. End-of-service commands come in two kinds. One clears a named level. The other clears whichever in-service level currently ranks highest. Automatic end-of-service skips the in-service bookkeeping altogether. Special mask mode lets masked in-service levels stop blocking lower requests.

The acknowledge flow is a two-state machine. In `SVC_IDLE` an acknowledge pulse is accepted and moves to `SVC_VEC`; this is the take transition when a request wins, or the spurious transition when none does. In `SVC_VEC` the vector is valid for one cycle, and the return transition goes back to `SVC_IDLE` unconditionally.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the request and in-service registers are empty, `int_out` and `vec_valid` are 0, and line 0 ranks highest with line 7 lowest.
- R2: A line whose `mask` bit is 1 never causes `int_out`, but its captured request stays pending and raises `int_out` once the bit returns to 0.
- R3: With the default ranking and nothing in service, the acknowledged request is the lowest-numbered unmasked pending line.
- R4: With `cfg_level_trig`=0, a request is captured on a rising edge of its line and stays pending after the line falls; a line held high is not captured again after service. With `cfg_level_trig`=1, the request follows the line one cycle later and vanishes when the line falls.
- R5: `int_out` is 1 only when the best unmasked pending request ranks strictly above the best in-service level, or nothing is in service.
- R6: An acknowledge pulse accepted in `SVC_IDLE` gives `vec_valid`=1 for exactly the next cycle. `vec_out` then equals `cfg_vec_base` with bits [2:0] replaced by the winning level. The winner leaves the request register and, without automatic end-of-service, enters the in-service register. If `int_out` was 0, the vector carries level 7 and no register changes.
- R7: With `cfg_auto_eoi`=1 an acknowledge leaves the in-service register unchanged, so a lower-ranked request raises `int_out` right away.
- R8: An `eoi_pulse` with `eoi_specific`=0 clears the highest-ranked set in-service bit under the current rotation.
- R9: An `eoi_pulse` with `eoi_specific`=1 clears exactly the in-service bit numbered by `eoi_level`.
- R10: An `eoi_pulse` with `eoi_rotate`=1 makes the cleared level the lowest-ranked, so the next level up the ring ranks highest. A `prio_set_pulse` makes `eoi_level` the lowest-ranked without clearing anything.
- R11: With `cfg_spec_mask`=1, in-service levels whose mask bit is 1 do not block requests, so a lower-ranked request can be signalled while such a level is in service.
- R12: An acknowledge pulse that arrives while in `SVC_VEC` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Request lines |
| mask | input | 8 | Per-line mask, 1 = masked |
| cfg_level_trig | input | 1 | 1 = level capture, 0 = rising-edge capture |
| cfg_auto_eoi | input | 1 | 1 = acknowledge does not set in-service |
| cfg_spec_mask | input | 1 | 1 = masked in-service levels stop blocking |
| cfg_vec_base | input | 8 | Vector base, bits [2:0] ignored |
| ack_pulse | input | 1 | Acknowledge strobe |
| eoi_pulse | input | 1 | End-of-service command strobe |
| eoi_specific | input | 1 | 1 = clear level `eoi_level`, 0 = clear highest in service |
| eoi_rotate | input | 1 | 1 = cleared level becomes lowest-ranked |
| eoi_level | input | 3 | Level field for specific EOI and priority set |
| prio_set_pulse | input | 1 | Make `eoi_level` the lowest-ranked |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledge |
| vec_valid | output | 1 | `vec_out` valid, one cycle |

## Verification
Simultaneous requests on two lines show whether arbitration follows ring rank rather than arrival. A nested case, with a lower line raised under an in-service level and then a higher one, tells strict rank comparison apart from simple pending detection. Specific and non-specific end-of-service are applied to a two-deep service stack, so clearing the wrong bit becomes visible on `int_out`. Rotation, priority-set, held-high edge lines, falling level lines, masked-in-service under special mask mode, and a stretched acknowledge each get their own pattern. Each pattern is chosen so that the expected vector differs from the one a default ranking would give.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [0:0] {
        SVC_IDLE = 1'b0,
        SVC_VEC  = 1'b1
    } svc_state_e;

endpackage

// File: rtl/irq_rot_pick.sv
// Finds the highest-ranked set bit of a vector under a rotating ring.
// Rank 0 is the position just above lowest_lvl.
module irq_rot_pick #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    input  logic [LW-1:0] lowest_lvl,
    output logic          found,
    output logic [LW-1:0] level,
    output logic [LW-1:0] rank
);

    logic [LW-1:0] idx;

    always_comb begin
        found = 1'b0;
        level = '0;
        rank  = '0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = lowest_lvl + LW'(1) + LW'(k);
            if (bits[idx]) begin
                found = 1'b1;
                level = idx;
                rank  = LW'(k);
            end
        end
    end

endmodule

// File: rtl/irq_req_reg.sv
// Request capture: per-line edge or level capture with acknowledge clear.
module irq_req_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic         level_mode,
    input  logic [N-1:0] clr_onehot,
    output logic [N-1:0] irr_q
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
                irr_q[i]  <= 1'b0;
            end else begin
                prev_q[i] <= irq_in[i];
                if (level_mode) begin
                    irr_q[i] <= irq_in[i] & ~clr_onehot[i];
                end else begin
                    irr_q[i] <= (irr_q[i] & ~clr_onehot[i])
                              | (irq_in[i] & ~prev_q[i]);
                end
            end
        end
    end

endmodule

// File: rtl/irq_svc_fsm.sv
// Acknowledge state machine, in-service register, rotation and vector.
module irq_svc_fsm
    import irq_prio_pkg::*;
#(
    parameter int N     = 8,
    parameter int LW    = $clog2(N),
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_pulse,
    input  logic             int_req,
    input  logic [LW-1:0]    win_level,
    input  logic             isr_top_found,
    input  logic [LW-1:0]    isr_top_level,
    input  logic             auto_eoi,
    input  logic [VEC_W-1:0] vec_base,
    input  logic             eoi_pulse,
    input  logic             eoi_specific,
    input  logic             eoi_rotate,
    input  logic [LW-1:0]    eoi_level,
    input  logic             prio_set_pulse,
    output logic [N-1:0]     isr_q,
    output logic [LW-1:0]    lowest_q,
    output logic             ack_take,
    output logic [N-1:0]     clr_onehot,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);

    svc_state_e   state_q, state_d;
    logic         ack_spur;
    logic         eoi_hit;
    logic [LW-1:0] eoi_lvl;
    logic [N-1:0] eoi_clr;
    logic [N-1:0] isr_set;
    logic [N-1:0] isr_d;
    logic [LW-1:0] lowest_d;
    logic [VEC_W-1:0] vec_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SVC_IDLE: if (ack_pulse) state_d = SVC_VEC;
            SVC_VEC:  state_d = SVC_IDLE;
            default:  state_d = SVC_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        ack_take  = 1'b0;
        ack_spur  = 1'b0;
        vec_valid = 1'b0;
        unique case (state_q)
            SVC_IDLE: begin
                ack_take = ack_pulse & int_req;
                ack_spur = ack_pulse & ~int_req;
            end
            SVC_VEC:  vec_valid = 1'b1;
            default:  vec_valid = 1'b0;
        endcase
    end

    // end-of-service target
    always_comb begin
        if (eoi_specific) begin
            eoi_hit = eoi_pulse;
            eoi_lvl = eoi_level;
        end else begin
            eoi_hit = eoi_pulse & isr_top_found;
            eoi_lvl = isr_top_level;
        end
        eoi_clr = '0;
        if (eoi_hit) eoi_clr[eoi_lvl] = 1'b1;
    end

    always_comb begin
        clr_onehot = '0;
        if (ack_take) clr_onehot[win_level] = 1'b1;
        isr_set = auto_eoi ? '0 : clr_onehot;
        isr_d   = (isr_q & ~eoi_clr) | isr_set;
    end

    always_comb begin
        lowest_d = lowest_q;
        if (eoi_hit && eoi_rotate) lowest_d = eoi_lvl;
        else if (prio_set_pulse)   lowest_d = eoi_level;
    end

    always_comb begin
        vec_d = vec_out;
        if (ack_take)      vec_d = {vec_base[VEC_W-1:LW], win_level};
        else if (ack_spur) vec_d = {vec_base[VEC_W-1:LW], {LW{1'b1}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q    <= '0;
            lowest_q <= LW'(N - 1);
            vec_out  <= '0;
        end else begin
            isr_q    <= isr_d;
            lowest_q <= lowest_d;
            vec_out  <= vec_d;
        end
    end

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
    parameter int NUM_IRQ = 8,
    parameter int VEC_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IRQ-1:0]       irq_in,
    input  logic [NUM_IRQ-1:0]       mask,
    input  logic                     cfg_level_trig,
    input  logic                     cfg_auto_eoi,
    input  logic                     cfg_spec_mask,
    input  logic [VEC_W-1:0]         cfg_vec_base,
    input  logic                     ack_pulse,
    input  logic                     eoi_pulse,
    input  logic                     eoi_specific,
    input  logic                     eoi_rotate,
    input  logic [$clog2(NUM_IRQ)-1:0] eoi_level,
    input  logic                     prio_set_pulse,
    output logic                     int_out,
    output logic [VEC_W-1:0]         vec_out,
    output logic                     vec_valid
);

    localparam int LW = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0] irr_q;
    logic [NUM_IRQ-1:0] isr_q;
    logic [NUM_IRQ-1:0] clr_onehot;
    logic [NUM_IRQ-1:0] req_cand;
    logic [NUM_IRQ-1:0] isr_block;
    logic [LW-1:0]      lowest_q;
    logic               ack_take;

    logic               req_found, blk_found, top_found;
    logic [LW-1:0]      req_level, blk_level, top_level;
    logic [LW-1:0]      req_rank,  blk_rank,  top_rank;
    logic               int_req;

    irq_req_reg #(.N(NUM_IRQ)) i_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .level_mode (cfg_level_trig),
        .clr_onehot (clr_onehot),
        .irr_q      (irr_q)
    );

    assign req_cand  = irr_q & ~mask;
    assign isr_block = cfg_spec_mask ? (isr_q & ~mask) : isr_q;

    irq_rot_pick #(.N(NUM_IRQ), .LW(LW)) i_pick_req (
        .bits       (req_cand),
        .lowest_lvl (lowest_q),
        .found      (req_found),
        .level      (req_level),
        .rank       (req_rank)
    );

    irq_rot_pick #(.N(NUM_IRQ), .LW(LW)) i_pick_blk (
        .bits       (isr_block),
        .lowest_lvl (lowest_q),
        .found      (blk_found),
        .level      (blk_level),
        .rank       (blk_rank)
    );

    irq_rot_pick #(.N(NUM_IRQ), .LW(LW)) i_pick_top (
        .bits       (isr_q),
        .lowest_lvl (lowest_q),
        .found      (top_found),
        .level      (top_level),
        .rank       (top_rank)
    );

    always_comb begin
        int_req = 1'b0;
        if (req_found) int_req = !blk_found || (req_rank < blk_rank);
    end

    assign int_out = int_req;

    irq_svc_fsm #(.N(NUM_IRQ), .LW(LW), .VEC_W(VEC_W)) i_svc (
        .clk            (clk),
        .rst_n          (rst_n),
        .ack_pulse      (ack_pulse),
        .int_req        (int_req),
        .win_level      (req_level),
        .isr_top_found  (top_found),
        .isr_top_level  (top_level),
        .auto_eoi       (cfg_auto_eoi),
        .vec_base       (cfg_vec_base),
        .eoi_pulse      (eoi_pulse),
        .eoi_specific   (eoi_specific),
        .eoi_rotate     (eoi_rotate),
        .eoi_level      (eoi_level),
        .prio_set_pulse (prio_set_pulse),
        .isr_q          (isr_q),
        .lowest_q       (lowest_q),
        .ack_take       (ack_take),
        .clr_onehot     (clr_onehot),
        .vec_out        (vec_out),
        .vec_valid      (vec_valid)
    );

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  mask,
    input logic [N-1:0]  irr_q,
    input logic [N-1:0]  isr_q,
    input logic          int_out,
    input logic          ack_take,
    input logic          ack_pulse,
    input logic          vec_valid,
    input logic          cfg_auto_eoi,
    input logic          eoi_pulse,
    input logic          eoi_specific,
    input logic [LW-1:0] eoi_level
);

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr_q & ~mask) != '0)); // R2

    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid); // R6

    AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_pulse)); // R6

    AST_ACK_ADDS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !cfg_auto_eoi && !eoi_pulse)
        |=> ($countones(isr_q) == $countones($past(isr_q)) + 1)); // R6

    AST_AUTO_EOI_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && cfg_auto_eoi && !eoi_pulse) |=> (isr_q == $past(isr_q))); // R7

    AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && eoi_specific && !ack_take) |=> !isr_q[$past(eoi_level)]); // R9

endmodule

bind irq_prio_core irq_prio_chk #(.N(NUM_IRQ), .LW(LW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask         (mask),
    .irr_q        (irr_q),
    .isr_q        (isr_q),
    .int_out      (int_out),
    .ack_take     (ack_take),
    .ack_pulse    (ack_pulse),
    .vec_valid    (vec_valid),
    .cfg_auto_eoi (cfg_auto_eoi),
    .eoi_pulse    (eoi_pulse),
    .eoi_specific (eoi_specific),
    .eoi_level    (eoi_level)
);

// File: tb/test_irq_prio_core.sv
`timescale 1ns/1ps
module test_irq_prio_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic [7:0] mask = '0;
    logic       cfg_level_trig = 1'b0;
    logic       cfg_auto_eoi = 1'b0;
    logic       cfg_spec_mask = 1'b0;
    logic [7:0] cfg_vec_base = 8'h40;
    logic       ack_pulse = 1'b0;
    logic       eoi_pulse = 1'b0;
    logic       eoi_specific = 1'b0;
    logic       eoi_rotate = 1'b0;
    logic [2:0] eoi_level = '0;
    logic       prio_set_pulse = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_core i_irq_prio_core (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask),
        .cfg_level_trig(cfg_level_trig), .cfg_auto_eoi(cfg_auto_eoi),
        .cfg_spec_mask(cfg_spec_mask), .cfg_vec_base(cfg_vec_base),
        .ack_pulse(ack_pulse), .eoi_pulse(eoi_pulse),
        .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate),
        .eoi_level(eoi_level), .prio_set_pulse(prio_set_pulse),
        .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // acknowledge and check the vector of the next cycle
    task automatic do_ack(input string req, input logic [7:0] exp_vec);
        ack_pulse = 1'b1;
        tick();
        ack_pulse = 1'b0;
        chk(req, {7'd0, vec_valid}, 8'd1);
        chk(req, vec_out, exp_vec);
        tick();
    endtask

    task automatic eoi(input bit spec, input bit rot, input logic [2:0] lvl);
        eoi_pulse = 1'b1; eoi_specific = spec; eoi_rotate = rot; eoi_level = lvl;
        tick();
        eoi_pulse = 1'b0; eoi_specific = 1'b0; eoi_rotate = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 int_out", {7'd0, int_out}, 8'd0);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
        do_ack("R6 spurious", 8'h47);
        chk("R6 spurious int_out", {7'd0, int_out}, 8'd0);
    endtask

    task automatic t_priority();
        irq_in = 8'b0010_0100; tick();
        chk("R3 int", {7'd0, int_out}, 8'd1);
        do_ack("R3 lowest line wins", 8'h42);
        chk("R5 blocked by service", {7'd0, int_out}, 8'd0);
        eoi(1'b0, 1'b0, 3'd0);
        chk("R8 nonspecific eoi", {7'd0, int_out}, 8'd1);
        do_ack("R6 next vector", 8'h45);
        eoi(1'b0, 1'b0, 3'd0);
        chk("R4 held edge not recaptured", {7'd0, int_out}, 8'd0);
        irq_in = '0; tick();
    endtask

    task automatic t_mask();
        mask = 8'h10; irq_in[4] = 1'b1; tick();
        chk("R2 masked silent", {7'd0, int_out}, 8'd0);
        irq_in = '0; tick();
        mask = '0; tick();
        chk("R2 kept pending", {7'd0, int_out}, 8'd1);
        do_ack("R2 vector", 8'h44);
        eoi(1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_level();
        cfg_level_trig = 1'b1;
        irq_in[6] = 1'b1; tick();
        chk("R4 level seen", {7'd0, int_out}, 8'd1);
        irq_in = '0; tick();
        chk("R4 level dropped", {7'd0, int_out}, 8'd0);
        cfg_level_trig = 1'b0; tick();
    endtask

    task automatic t_aeoi();
        cfg_auto_eoi = 1'b1;
        irq_in[1] = 1'b1; tick();
        do_ack("R7 vector", 8'h41);
        irq_in[3] = 1'b1; tick();
        chk("R7 no service block", {7'd0, int_out}, 8'd1);
        do_ack("R7 second vector", 8'h43);
        cfg_auto_eoi = 1'b0;
        irq_in = '0; tick();
        chk("R7 idle after", {7'd0, int_out}, 8'd0);
    endtask

    task automatic t_spec_eoi();
        irq_in[2] = 1'b1; tick();
        do_ack("R6 level 2", 8'h42);
        irq_in[0] = 1'b1; tick();
        chk("R5 higher nests", {7'd0, int_out}, 8'd1);
        do_ack("R5 level 0", 8'h40);
        irq_in[1] = 1'b1; tick();
        chk("R5 lower waits", {7'd0, int_out}, 8'd0);
        eoi(1'b1, 1'b0, 3'd2);
        chk("R9 clears only 2", {7'd0, int_out}, 8'd0);
        eoi(1'b1, 1'b0, 3'd0);
        chk("R9 clears 0", {7'd0, int_out}, 8'd1);
        do_ack("R9 level 1", 8'h41);
        eoi(1'b0, 1'b0, 3'd0);
        irq_in = '0; tick();
        irq_in[3] = 1'b1; tick();
        chk("R9 level 2 was cleared", {7'd0, int_out}, 8'd1);
        do_ack("R9 level 3", 8'h43);
        eoi(1'b0, 1'b0, 3'd0);
        irq_in = '0; tick();
    endtask

    task automatic t_rotate();
        irq_in[3] = 1'b1; tick();
        do_ack("R10 level 3", 8'h43);
        eoi(1'b0, 1'b1, 3'd0);
        irq_in = '0; tick();
        irq_in = 8'b0010_0100; tick();
        do_ack("R10 rotated winner", 8'h45);
        eoi(1'b0, 1'b0, 3'd0);
        eoi_level = 3'd7; prio_set_pulse = 1'b1; tick();
        prio_set_pulse = 1'b0;
        irq_in = '0; tick();
        irq_in[5] = 1'b1; tick();
        do_ack("R10 priority set restores", 8'h42);
        eoi(1'b0, 1'b0, 3'd0);
        do_ack("R10 then 5", 8'h45);
        eoi(1'b0, 1'b0, 3'd0);
        irq_in = '0; tick();
    endtask

    task automatic t_smm();
        cfg_spec_mask = 1'b1;
        irq_in[1] = 1'b1; tick();
        do_ack("R11 level 1", 8'h41);
        irq_in[4] = 1'b1; tick();
        chk("R11 unmasked service blocks", {7'd0, int_out}, 8'd0);
        mask = 8'h02; tick();
        chk("R11 masked service lets through", {7'd0, int_out}, 8'd1);
        do_ack("R11 level 4", 8'h44);
        eoi(1'b1, 1'b0, 3'd4);
        eoi(1'b1, 1'b0, 3'd1);
        mask = '0; cfg_spec_mask = 1'b0;
        irq_in = '0; tick();
    endtask

    task automatic t_ack_hold();
        irq_in = 8'b0100_1000; tick();
        ack_pulse = 1'b1; tick();
        chk("R12 first vector", vec_out, 8'h43);
        tick();
        ack_pulse = 1'b0;
        chk("R12 no second vector", {7'd0, vec_valid}, 8'd0);
        tick();
        chk("R12 line 6 still waits", {7'd0, int_out}, 8'd0);
        eoi(1'b0, 1'b0, 3'd0);
        chk("R12 line 6 pending", {7'd0, int_out}, 8'd1);
        do_ack("R12 line 6 vector", 8'h46);
        eoi(1'b0, 1'b0, 3'd0);
        irq_in = '0; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_priority();
        t_mask();
        t_level();
        t_aeoi();
        t_spec_eoi();
        t_rotate();
        t_smm();
        t_ack_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule